// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the byte-wide register port of a single eight-line interrupt controller unit. It sits between a processor-side bus with one address bit and the controller core that holds the request and in-service registers. It turns the byte writes it receives into the controller's configuration and into per-line clear pulses. It also answers register reads and one-shot poll reads.

A write to address 0 with bit 4 set starts an initialization sequence. The following writes to address 1 are taken as further setup words: the vector base, a cascade word that the block skips, and an optional format word. Other writes to address 0 are either mode commands (poll request, read select, special mask) or operation commands, chosen by the top three data bits. The operation commands end interrupts, set the rotating priority base, or set the rotate-on-auto-end flag. The winning line for a poll read comes from an external resolver. The block itself finds the highest-priority in-service line for the non-specific end commands.

Top module: `icr_port`

## Requirements
- R1: A write to address 0 with data bit 4 set raises `init_pulse` in that cycle. After the edge, the mask, priority base, vector base and all mode flags are zero, poll and read select are cleared, and data bit 0 is recorded as "format word needed".
- R2: After R1, the next write to address 1 loads `vec_base` with data AND 0xF8. The write after that is skipped. If a format word is needed, a third write sets `nested_mode` from data bit 4 and `auto_eoi` from data bit 1. The sequence then returns to idle.
- R3: A write to address 1 while idle loads `mask`. A write to address 1 during the sequence leaves `mask` unchanged.
- R4: A write to address 0 with bit 4 = 0 and bit 3 = 1 is a mode command. Bit 2 = 1 arms a poll. If bit 1 = 1, bit 0 picks the read-back source (1 = in-service, 0 = request). If bit 6 = 1, bit 5 loads `special_mask`.
- R5: For an operation command (bits 4 and 3 both 0), code = data[7:5]. Codes 1 and 5 pulse `isr_clr` for the highest-priority set in-service line, if there is one. Codes 3 and 7 pulse `isr_clr` for line data[2:0].
- R6: Code 5 sets `prio_base` to the cleared line + 1, and only if a line was found. Code 7 sets it to data[2:0] + 1, and code 6 does the same. All of these wrap modulo 8. Code 0 clears `rot_auto_eoi` and code 4 sets it. Code 2 changes nothing. Line priority counts upward from `prio_base`, wrapping.
- R7: A read while a poll is armed returns `win_line` one cycle later and pulses both `isr_clr` and `irr_clr` for that line in the read cycle. If `win_valid` is 0, the read returns 7 and pulses nothing. In either case the poll is disarmed.
- R8: A read with no poll armed returns, one cycle later, the mask for address 1, or the selected in-service or request vector for address 0.
- R9: After reset all outputs are zero and the block is idle with no poll armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 1 | Register address bit |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| irr_in | input | LINES | Request vector from the core |
| isr_in | input | LINES | In-service vector from the core |
| win_valid | input | 1 | Resolver has a winning line |
| win_line | input | LW | Winning line number |
| rd_data | output | 8 | Registered read data |
| mask | output | LINES | Line mask |
| vec_base | output | 8 | Vector base |
| prio_base | output | LW | Rotating priority base |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| rot_auto_eoi | output | 1 | Rotate on automatic end |
| nested_mode | output | 1 | Special fully nested mode |
| special_mask | output | 1 | Special mask mode |
| init_pulse | output | 1 | Core clear / interrupt drop request |
| isr_clr | output | LINES | In-service clear pulses |
| irr_clr | output | LINES | Request clear pulses |

## Verification
On every cycle, the assertions check four things: the setup sequence steps in order, the mask holds while the sequence runs, a poll read disarms the poll and returns an in-range line, and a single command never clears more than one in-service line. Other behaviours only show up in the bench's scenarios, against a reference model. These are the rotating search for the highest-priority in-service line, the base arithmetic wrapping past line 7, the choice of read-back source, and the format word setting the mode flags.

// File: rtl/icr_pkg.sv
package icr_pkg;
   localparam int DW = 8;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_BASE = 2'd1,
      SEQ_CASC = 2'd2,
      SEQ_FMT  = 2'd3
   } seq_st_e;

   typedef enum logic [2:0] {
      OP_ROT_OFF   = 3'd0,
      OP_END_TOP   = 3'd1,
      OP_NONE      = 3'd2,
      OP_END_LINE  = 3'd3,
      OP_ROT_ON    = 3'd4,
      OP_END_ROT   = 3'd5,
      OP_SET_BASE  = 3'd6,
      OP_LINE_ROT  = 3'd7
   } op_code_e;
endpackage

// File: rtl/icr_prio_pick.sv
module icr_prio_pick #(
   parameter int LINES = 8,
   localparam int LW = $clog2(LINES)
) (
   input  logic [LINES-1:0] vec,
   input  logic [LW-1:0]    base,
   output logic             hit,
   output logic [LW-1:0]    line
);
   always_comb begin
      hit  = 1'b0;
      line = '0;
      for (int k = LINES - 1; k >= 0; k--) begin
         logic [LW-1:0] idx;
         idx = base + LW'(k);
         if (vec[idx]) begin
            hit  = 1'b1;
            line = idx;
         end
      end
   end
endmodule

// File: rtl/icr_init_fsm.sv
module icr_init_fsm
   import icr_pkg::*;
#(
   parameter int LINES = 8,
   localparam int LW = $clog2(LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          need_fmt,
   input  logic          word_wr,
   input  logic [DW-1:0] word,
   output logic          idle,
   output logic [DW-1:0] vec_base,
   output logic          nested,
   output logic          auto_eoi
);
   seq_st_e st_q;
   logic    fmt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= SEQ_IDLE;
         fmt_q    <= 1'b0;
         vec_base <= '0;
         nested   <= 1'b0;
         auto_eoi <= 1'b0;
      end else if (start) begin
         st_q     <= SEQ_BASE;
         fmt_q    <= need_fmt;
         vec_base <= '0;
         nested   <= 1'b0;
         auto_eoi <= 1'b0;
      end else if (word_wr) begin
         unique case (st_q)
            SEQ_IDLE: st_q <= SEQ_IDLE;
            SEQ_BASE: begin
               vec_base <= {word[DW-1:LW], LW'(0)};
               st_q     <= SEQ_CASC;
            end
            SEQ_CASC: st_q <= fmt_q ? SEQ_FMT : SEQ_IDLE;
            SEQ_FMT: begin
               nested   <= word[4];
               auto_eoi <= word[1];
               st_q     <= SEQ_IDLE;
            end
         endcase
      end
   end

   assign idle = (st_q == SEQ_IDLE);

   AST_START_ENTERS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> st_q == SEQ_BASE) else $error("start"); // R1
   AST_BASE_TO_CASC: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_BASE && word_wr && !start) |=> st_q == SEQ_CASC) else $error("seq"); // R2
   AST_FMT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SEQ_FMT && word_wr && !start) |=> st_q == SEQ_IDLE) else $error("fmt"); // R2
endmodule

// File: rtl/icr_readback.sv
module icr_readback
   import icr_pkg::*;
#(
   parameter int LINES = 8,
   localparam int LW = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic             addr,
   input  logic             poll,
   input  logic             win_valid,
   input  logic [LW-1:0]    win_line,
   input  logic             sel_isr,
   input  logic [LINES-1:0] irr,
   input  logic [LINES-1:0] isr,
   input  logic [LINES-1:0] mask,
   output logic [DW-1:0]    rd_data
);
   logic [DW-1:0] nxt;

   always_comb begin
      if (poll)
         nxt = win_valid ? DW'(win_line) : DW'(LINES - 1);
      else if (addr)
         nxt = DW'(mask);
      else
         nxt = sel_isr ? DW'(isr) : DW'(irr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data <= '0;
      else if (rd_en)   rd_data <= nxt;
   end

   AST_POLL_EMPTY_SEVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && poll && !win_valid) |=> rd_data == DW'(LINES - 1)) else $error("poll empty"); // R7
   AST_POLL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && poll) |=> rd_data < DW'(LINES)) else $error("poll range"); // R7
endmodule

// File: rtl/icr_port.sv
module icr_port
   import icr_pkg::*;
#(
   parameter int LINES = 8,
   localparam int LW = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr,
   input  logic             wr_en,
   input  logic [DW-1:0]    wr_data,
   input  logic             rd_en,
   input  logic [LINES-1:0] irr_in,
   input  logic [LINES-1:0] isr_in,
   input  logic             win_valid,
   input  logic [LW-1:0]    win_line,
   output logic [DW-1:0]    rd_data,
   output logic [LINES-1:0] mask,
   output logic [DW-1:0]    vec_base,
   output logic [LW-1:0]    prio_base,
   output logic             auto_eoi,
   output logic             rot_auto_eoi,
   output logic             nested_mode,
   output logic             special_mask,
   output logic             init_pulse,
   output logic [LINES-1:0] isr_clr,
   output logic [LINES-1:0] irr_clr
);
   generate
      if (LINES < 2 || LINES > DW || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
         $error("LINES must be a power of two between 2 and 8");
      end
   endgenerate

   logic init_wr, mode_wr, op_wr, word_wr, mask_wr, poll_rd;
   logic seq_idle, top_hit, poll_q, sel_isr_q;
   logic [LW-1:0] top_line, named, pbase_nx;
   logic rot_nx;
   op_code_e op;

   assign init_wr = wr_en && !addr && wr_data[4];
   assign mode_wr = wr_en && !addr && !wr_data[4] && wr_data[3];
   assign op_wr   = wr_en && !addr && !wr_data[4] && !wr_data[3];
   assign word_wr = wr_en && addr && !init_wr;
   assign mask_wr = word_wr && seq_idle;
   assign poll_rd = rd_en && poll_q;
   assign op      = op_code_e'(wr_data[7:5]);
   assign named   = wr_data[LW-1:0];
   assign init_pulse = init_wr;

   icr_init_fsm #(.LINES(LINES)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(init_wr), .need_fmt(wr_data[0]),
      .word_wr(word_wr), .word(wr_data), .idle(seq_idle),
      .vec_base(vec_base), .nested(nested_mode), .auto_eoi(auto_eoi)
   );

   icr_prio_pick #(.LINES(LINES)) u_pick (
      .vec(isr_in), .base(prio_base), .hit(top_hit), .line(top_line)
   );

   always_comb begin
      isr_clr  = '0;
      irr_clr  = '0;
      pbase_nx = prio_base;
      rot_nx   = rot_auto_eoi;
      if (op_wr) begin
         unique case (op)
            OP_ROT_OFF, OP_ROT_ON: rot_nx = op[2];
            OP_END_TOP: if (top_hit) isr_clr[top_line] = 1'b1;
            OP_END_ROT: if (top_hit) begin
               isr_clr[top_line] = 1'b1;
               pbase_nx = top_line + LW'(1);
            end
            OP_END_LINE: isr_clr[named] = 1'b1;
            OP_SET_BASE: pbase_nx = named + LW'(1);
            OP_LINE_ROT: begin
               isr_clr[named] = 1'b1;
               pbase_nx = named + LW'(1);
            end
            OP_NONE: ;
         endcase
      end
      if (poll_rd && win_valid) begin
         isr_clr[win_line] = 1'b1;
         irr_clr[win_line] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask         <= '0;
         prio_base    <= '0;
         rot_auto_eoi <= 1'b0;
         poll_q       <= 1'b0;
         sel_isr_q    <= 1'b0;
         special_mask <= 1'b0;
      end else if (init_wr) begin
         mask         <= '0;
         prio_base    <= '0;
         rot_auto_eoi <= 1'b0;
         poll_q       <= 1'b0;
         sel_isr_q    <= 1'b0;
         special_mask <= 1'b0;
      end else begin
         if (mask_wr) mask <= wr_data[LINES-1:0];
         prio_base    <= pbase_nx;
         rot_auto_eoi <= rot_nx;
         if (mode_wr && wr_data[2]) poll_q <= 1'b1;
         else if (rd_en)            poll_q <= 1'b0;
         if (mode_wr && wr_data[1]) sel_isr_q    <= wr_data[0];
         if (mode_wr && wr_data[6]) special_mask <= wr_data[5];
      end
   end

   icr_readback #(.LINES(LINES)) u_rb (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .poll(poll_q),
      .win_valid(win_valid), .win_line(win_line), .sel_isr(sel_isr_q),
      .irr(irr_in), .isr(isr_in), .mask(mask), .rd_data(rd_data)
   );

   AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      init_wr |=> (mask == '0 && prio_base == '0 && !rot_auto_eoi && !special_mask)) else $error("init"); // R1
   AST_MASK_HELD_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (word_wr && !seq_idle) |=> $stable(mask)) else $error("mask"); // R3
   AST_POLL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_rd && !wr_en) |=> !poll_q) else $error("poll"); // R7
   AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_wr && poll_rd) |-> $onehot0(isr_clr)) else $error("clr"); // R5
   AST_REQ_CLR_ONLY_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      !poll_rd |-> irr_clr == '0) else $error("irr clr"); // R7
endmodule

// File: tb/icr_port_test.sv
`timescale 1ns/1ps
module icr_port_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, win_valid = 1'b0;
   logic [7:0] wr_data = '0, irr_in = '0, isr_in = '0;
   logic [2:0] win_line = '0;
   logic [7:0] rd_data, mask, vec_base, isr_clr, irr_clr;
   logic [2:0] prio_base;
   logic auto_eoi, rot_auto_eoi, nested_mode, special_mask, init_pulse;

   int vectors = 0, errors = 0;

   // reference model
   logic [7:0] m_mask = '0, m_vb = '0;
   logic [2:0] m_pb = '0;
   logic m_rot = 0, m_aeoi = 0, m_nest = 0, m_smask = 0, m_poll = 0, m_rsel = 0, m_n4 = 0;
   int   m_st = 0;

   always #4 clk = ~clk;

   icr_port uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .irr_in(irr_in), .isr_in(isr_in), .win_valid(win_valid),
      .win_line(win_line), .rd_data(rd_data), .mask(mask), .vec_base(vec_base),
      .prio_base(prio_base), .auto_eoi(auto_eoi), .rot_auto_eoi(rot_auto_eoi),
      .nested_mode(nested_mode), .special_mask(special_mask),
      .init_pulse(init_pulse), .isr_clr(isr_clr), .irr_clr(irr_clr)
   );

   function automatic logic [3:0] top_of(input logic [7:0] v, input logic [2:0] b);
      for (int k = 0; k < 8; k++) begin
         logic [2:0] i;
         i = b + 3'(k);
         if (v[i]) return {1'b1, i};
      end
      return 4'h0;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input logic a, input logic we, input logic [7:0] d, input logic re,
                       input logic [7:0] irr, input logic [7:0] isr,
                       input logic wv, input logic [2:0] wl);
      logic [7:0] e_ic, e_rc, e_rd;
      logic e_init, is_init, is_mode, is_op;
      logic [3:0] t;
      logic [2:0] code;
      addr = a; wr_en = we; wr_data = d; rd_en = re;
      irr_in = irr; isr_in = isr; win_valid = wv; win_line = wl;
      is_init = we && !a && d[4];
      is_mode = we && !a && !d[4] && d[3];
      is_op   = we && !a && !d[4] && !d[3];
      code = d[7:5];
      t = top_of(isr, m_pb);
      e_ic = '0; e_rc = '0; e_init = is_init;
      if (is_op) begin
         if ((code == 3'd1 || code == 3'd5) && t[3]) e_ic[t[2:0]] = 1'b1;
         if (code == 3'd3 || code == 3'd7) e_ic[d[2:0]] = 1'b1;
      end
      if (re && m_poll && wv) begin e_ic[wl] = 1'b1; e_rc[wl] = 1'b1; end
      if (m_poll) e_rd = wv ? {5'd0, wl} : 8'd7;
      else if (a) e_rd = m_mask;
      else e_rd = m_rsel ? isr : irr;
      #1;
      chk("R1", "init_pulse", init_pulse, e_init);
      chk("R5", "isr_clr", isr_clr, e_ic);
      chk("R7", "irr_clr", irr_clr, e_rc);
      @(posedge clk);
      if (is_init) begin
         m_mask = 0; m_pb = 0; m_vb = 0; m_rot = 0; m_aeoi = 0; m_nest = 0;
         m_smask = 0; m_poll = 0; m_rsel = 0; m_st = 1; m_n4 = d[0];
      end else begin
         if (is_mode && d[2]) m_poll = 1; else if (re) m_poll = 0;
         if (is_mode && d[1]) m_rsel = d[0];
         if (is_mode && d[6]) m_smask = d[5];
         if (is_op) case (code)
            3'd0, 3'd4: m_rot = code[2];
            3'd5: if (t[3]) m_pb = t[2:0] + 3'd1;
            3'd6, 3'd7: m_pb = d[2:0] + 3'd1;
            default: ;
         endcase
         if (we && a) case (m_st)
            0: m_mask = d;
            1: begin m_vb = d & 8'hF8; m_st = 2; end
            2: m_st = m_n4 ? 3 : 0;
            default: begin m_nest = d[4]; m_aeoi = d[1]; m_st = 0; end
         endcase
      end
      @(negedge clk);
      wr_en = 0; rd_en = 0;
      chk("R3", "mask", mask, m_mask);
      chk("R2", "vec_base", vec_base, m_vb);
      chk("R2", "auto_eoi", auto_eoi, m_aeoi);
      chk("R2", "nested_mode", nested_mode, m_nest);
      chk("R6", "prio_base", prio_base, m_pb);
      chk("R6", "rot_auto_eoi", rot_auto_eoi, m_rot);
      chk("R4", "special_mask", special_mask, m_smask);
      if (re) chk("R8", "rd_data", rd_data, e_rd);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R9: reset values
      chk("R9", "mask", mask, 0);
      chk("R9", "vec_base", vec_base, 0);
      chk("R9", "prio_base", prio_base, 0);
      chk("R9", "flags", {auto_eoi, rot_auto_eoi, nested_mode, special_mask}, 0);
      chk("R9", "rd_data", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1/R2: full setup with format word
      step(0, 1, 8'h11, 0, 0, 0, 0, 0);
      step(1, 1, 8'hA5, 0, 0, 0, 0, 0);
      step(1, 1, 8'h3C, 0, 0, 0, 0, 0);   // R3: skipped, mask untouched
      step(1, 1, 8'h12, 0, 0, 0, 0, 0);
      step(1, 1, 8'h3C, 0, 0, 0, 0, 0);   // R3: mask load when idle
      // R5/R6: rotating end on top line, then plain end from the new base
      step(0, 1, 8'hA0, 0, 0, 8'h14, 0, 0);
      step(0, 1, 8'h20, 0, 0, 8'h14, 0, 0);
      step(0, 1, 8'hE7, 0, 0, 8'h80, 0, 0); // R6: wrap to 0
      step(0, 1, 8'hC2, 0, 0, 0, 0, 0);
      step(0, 1, 8'h40, 0, 0, 8'hFF, 0, 0); // R6: code 2 no effect
      step(0, 1, 8'hA0, 0, 0, 8'h00, 0, 0); // R6: no line, base held
      // R7: poll empty and poll hit
      step(0, 1, 8'h0C, 0, 0, 0, 0, 0);
      step(0, 0, 8'h00, 1, 8'hFF, 8'hFF, 0, 3);
      step(0, 1, 8'h0C, 0, 0, 0, 0, 0);
      step(1, 0, 8'h00, 1, 8'h20, 0, 1, 5);
      step(1, 0, 8'h00, 1, 8'h20, 0, 1, 5); // poll consumed, mask read
      // R4/R8: read select and special mask
      step(0, 1, 8'h6B, 0, 0, 0, 0, 0);
      step(0, 0, 8'h00, 1, 8'hA5, 8'h5A, 0, 0);
      step(0, 1, 8'h4A, 0, 0, 0, 0, 0);
      step(0, 1, 8'h0A, 0, 0, 0, 0, 0);
      step(0, 0, 8'h00, 1, 8'hA5, 8'h5A, 0, 0);
      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [7:0] d;
         int kind;
         kind = $urandom % 8;
         d = 8'($urandom);
         case (kind)
            0: if (($urandom % 4) == 0) step(0, 1, d | 8'h10, 0, 8'($urandom), 8'($urandom), 0, 0);
               else step(1, 1, d, 0, 0, 0, 0, 0);
            1, 2: step(1, 1, d, 0, 8'($urandom), 8'($urandom), 0, 0);
            3: step(0, 1, (d & 8'hE7) | 8'h08, 0, 0, 0, 0, 0);
            4, 5: step(0, 1, d & 8'hE7, 0, 8'($urandom), 8'($urandom), 1'($urandom), 3'($urandom));
            default: step(1'($urandom), 0, 0, 1, 8'($urandom), 8'($urandom), 1'($urandom), 3'($urandom));
         endcase
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule